// File: doc/BRIEF.md
# Status pin mode configurator

This block drives the single status output of a flash controller. After reset the pin reports readiness as a level. It is low while the write engine is busy. It is high when the engine is ready or suspended. Software can reprogram the pin with a two-write command sequence. The first write is a setup opcode. The second write is a code byte that either restores the level behaviour or selects a pulse mode. In pulse mode the pin rests high and drops low for a fixed number of clock cycles when an erase completes, when a program completes, or on either event, depending on the code.

A code byte is refused in two cases: its value is outside the four defined codes, or the engine is busy or suspended when it arrives. A refused code leaves the current mode in place and reports the failure to the status register. It does this with a one-cycle set mask that carries bits 4 and 5. The command bus, the engine flags and the completion strobes are plain control signals sampled on the rising clock edge. The block has no handshake and never stalls the bus.

Top module: `stspin_mode_top`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, the block is in level mode with `sr_set` = 8'h00. With `dev_busy` low, `sts_pin` is high.
- R2: In level mode `sts_pin` equals the inverse of (`dev_busy` and not `dev_susp`) sampled at the previous clock edge. So the pin is low when busy, high when ready, and high when suspended.
- R3: A write of `SETUP_OP` (default 8'hB8) followed by a second write of a code byte is a configuration command. An accepted code takes effect from the edge that captures it and raises no error.
- R4: Code 8'h01 selects erase-pulse mode. An `erase_done` strobe produces a low pulse, and `prog_done` has no effect on the pin.
- R5: Code 8'h02 selects program-pulse mode. A `prog_done` strobe produces a low pulse, and `erase_done` has no effect on the pin.
- R6: Code 8'h03 selects dual-pulse mode. Either strobe produces a low pulse.
- R7: In a pulse mode, an enabled strobe captured at edge E holds `sts_pin` low for exactly `PULSE_CYC` cycles starting at E (default 50 cycles, 250 ns at 200 MHz). Otherwise the pin is high regardless of `dev_busy`.
- R8: An enabled strobe that arrives during a pulse restarts the count, so the pin stays low for `PULSE_CYC` cycles after the latest strobe.
- R9: Code 8'h00 returns the pin to level mode.
- R10: A code byte above 8'h03 is rejected. The mode is unchanged, and `sr_set` shows 8'h30 (bits 4 and 5) for exactly one cycle after the capturing edge.
- R11: A code byte captured while `dev_busy` or `dev_susp` is high is rejected in the same way as R10, whatever its value.
- R12: Asserting `rst_n` low while any pulse mode is active returns the block to level mode.
- R13: Writes whose first byte is not `SETUP_OP` neither change the mode nor raise an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command write strobe, one byte per cycle |
| cmd_data | input | 8 | Command byte |
| dev_busy | input | 1 | Write engine busy |
| dev_susp | input | 1 | Write engine suspended |
| erase_done | input | 1 | One-cycle erase-complete strobe |
| prog_done | input | 1 | One-cycle program-complete strobe |
| sts_pin | output | 1 | Status pin, active-low busy or pulse |
| sr_set | output | 8 | One-cycle status register set mask |

## Verification
The busy and suspend flags are driven in every combination while the pin is in level mode. This separates the suspended-reads-high rule from plain busy inversion. Each pulse code is then tried with erase-only, program-only and overlapping strobes. These patterns distinguish the enable bits from one another, and an exact cycle count of the low phase exposes off-by-one widths and missing retriggers. Out-of-range codes, codes sent while the engine is busy or suspended, bare code bytes without the setup opcode, and a reset in the middle of a pulse each show whether the mode survives. The surviving mode is observed by later busy or strobe stimulus at the pin.

// File: rtl/stspin_pkg.sv
package stspin_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_ERASE = 2'b01,
    MODE_PROG  = 2'b10,
    MODE_BOTH  = 2'b11
  } pin_mode_e;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_ARMED
  } seq_state_e;

  localparam int unsigned SR_FAIL_A = 4;
  localparam int unsigned SR_FAIL_B = 5;

  typedef struct packed {
    logic       apply;
    logic       fault;
    logic [1:0] code;
  } cfg_req_t;
endpackage

// File: rtl/stspin_cmd_seq.sv
module stspin_cmd_seq
  import stspin_pkg::*;
#(
  parameter int unsigned CMD_W    = 8,
  parameter logic [7:0]  SETUP_OP = 8'hB8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CMD_W-1:0] data,
  input  logic             busy,
  input  logic             susp,
  output cfg_req_t         req
);
  localparam int unsigned HI_W = CMD_W - 2;

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    req     = '0;
    if (we) begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (data == CMD_W'(SETUP_OP)) state_d = SEQ_ARMED;
        end
        SEQ_ARMED: begin
          state_d = SEQ_IDLE;
          if (busy || susp) begin
            req.fault = 1'b1;
          end else if (data[CMD_W-1:2] != HI_W'(0)) begin
            req.fault = 1'b1;
          end else begin
            req.apply = 1'b1;
            req.code  = data[1:0];
          end
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  // R3
  armed_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_ARMED && we) |=> (state_q == SEQ_IDLE));

  // R13
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE) |-> !(req.apply || req.fault));
endmodule

// File: rtl/stspin_mode_reg.sv
module stspin_mode_reg
  import stspin_pkg::*;
#(
  parameter int unsigned SR_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cfg_req_t        req,
  output pin_mode_e       mode,
  output logic [SR_W-1:0] sr_set
);
  localparam logic [SR_W-1:0] FAIL_MASK =
    (SR_W'(1) << SR_FAIL_A) | (SR_W'(1) << SR_FAIL_B);

  pin_mode_e       mode_q;
  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_LEVEL;
      sr_q   <= '0;
    end else begin
      if (req.apply) mode_q <= pin_mode_e'(req.code);
      sr_q <= req.fault ? FAIL_MASK : '0;
    end
  end

  assign mode   = mode_q;
  assign sr_set = sr_q;

  // R10
  fault_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req.fault |=> $stable(mode_q));

  // R10
  sr_mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q == '0) || (sr_q == FAIL_MASK));

  // R10
  sr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q != '0 && !req.fault) |=> (sr_q == '0));
endmodule

// File: rtl/stspin_pulse_timer.sv
module stspin_pulse_timer #(
  parameter int unsigned PULSE_CYC = 50,
  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             fire,
  output logic [CNT_W-1:0] cnt,
  output logic             active
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clear)           cnt_q <= '0;
    else if (fire)            cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt    = cnt_q;
  assign active = (cnt_q != '0);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);

  // R8
  retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clear) |=> (cnt_q == LOAD));
endmodule

// File: rtl/stspin_mode_top.sv
module stspin_mode_top
  import stspin_pkg::*;
#(
  parameter int unsigned CMD_W     = 8,
  parameter logic [7:0]  SETUP_OP  = 8'hB8,
  parameter int unsigned PULSE_CYC = 50,
  parameter int unsigned SR_W      = 8,
  localparam int unsigned CNT_W    = $clog2(PULSE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             dev_busy,
  input  logic             dev_susp,
  input  logic             erase_done,
  input  logic             prog_done,
  output logic             sts_pin,
  output logic [SR_W-1:0]  sr_set
);
  cfg_req_t         req;
  pin_mode_e        mode;
  logic [CNT_W-1:0] cnt;
  logic             pulse_on;
  logic             fire;
  logic             level_q;

  stspin_cmd_seq #(.CMD_W(CMD_W), .SETUP_OP(SETUP_OP)) u_seq (
    .clk(clk), .rst_n(rst_n), .we(cmd_we), .data(cmd_data),
    .busy(dev_busy), .susp(dev_susp), .req(req)
  );

  stspin_mode_reg #(.SR_W(SR_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .sr_set(sr_set)
  );

  assign fire = (erase_done && mode[0]) || (prog_done && mode[1]);

  stspin_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(req.apply), .fire(fire),
    .cnt(cnt), .active(pulse_on)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b1;
    else        level_q <= !(dev_busy && !dev_susp);
  end

  always_comb begin
    if (mode == MODE_LEVEL) sts_pin = level_q;
    else                    sts_pin = !pulse_on;
  end

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LEVEL && !req.apply) |=> (sts_pin == !($past(dev_busy) && !$past(dev_susp))));

  // R7
  pulse_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_LEVEL && cnt == '0) |-> sts_pin);

  // R7
  pulse_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_LEVEL && cnt != '0 && !fire && !req.apply) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R4
  erase_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ERASE && !erase_done && cnt == '0 && !req.apply) |=> sts_pin);
endmodule

// File: tb/sim_stspin_mode_top.sv
`timescale 1ns/1ps
module sim_stspin_mode_top;
  localparam int unsigned PW = 50;
  localparam logic [7:0]  OP = 8'hB8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       dev_busy = 1'b0;
  logic       dev_susp = 1'b0;
  logic       erase_done = 1'b0;
  logic       prog_done = 1'b0;
  logic       sts_pin;
  logic [7:0] sr_set;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  stspin_mode_top u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .dev_busy(dev_busy), .dev_susp(dev_susp), .erase_done(erase_done),
    .prog_done(prog_done), .sts_pin(sts_pin), .sr_set(sr_set)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    cmd_we = 1'b1; cmd_data = b;
    @(negedge clk);
    cmd_we = 1'b0; cmd_data = 8'h00;
  endtask

  task automatic cfg(input logic [7:0] code);
    wr(OP);
    wr(code);
  endtask

  task automatic set_flags(input logic b, input logic s);
    dev_busy = b; dev_susp = s;
    @(negedge clk);
  endtask

  // strobe: sel 1 = erase, 2 = program, 3 = both; returns after capture edge
  task automatic strobe(input int sel);
    erase_done = sel[0]; prog_done = sel[1];
    @(negedge clk);
    erase_done = 1'b0; prog_done = 1'b0;
  endtask

  function automatic int dummy(input int x); return x; endfunction

  task automatic count_low(output int n);
    n = 0;
    while (sts_pin == 1'b0 && n < 400) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 pin in reset", sts_pin, 1);
    chk("R1 sr_set in reset", sr_set, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pin after reset", sts_pin, 1);
    chk("R1 sr_set after reset", sr_set, 0);
  endtask

  task automatic t_level();
    set_flags(1, 0); chk("R2 busy low", sts_pin, 0);
    set_flags(1, 1); chk("R2 suspended high", sts_pin, 1);
    set_flags(0, 1); chk("R2 susp only high", sts_pin, 1);
    set_flags(0, 0); chk("R2 ready high", sts_pin, 1);
  endtask

  task automatic t_erase_mode();
    int n;
    cfg(8'h01);
    chk("R3 accepted no error", sr_set, 0);
    set_flags(1, 0);
    chk("R7 idle high while busy", sts_pin, 1);
    set_flags(0, 0);
    strobe(1);
    count_low(n);
    chk("R4 R7 erase pulse width", n, PW);
    strobe(2);
    n = 0;
    repeat (PW + 5) begin
      if (sts_pin == 1'b0) n++;
      @(negedge clk);
    end
    chk("R4 program strobe ignored", n, 0);
  endtask

  task automatic t_prog_mode();
    int n;
    cfg(8'h02);
    strobe(2);
    count_low(n);
    chk("R5 program pulse width", n, PW);
    strobe(1);
    n = 0;
    repeat (PW + 5) begin
      if (sts_pin == 1'b0) n++;
      @(negedge clk);
    end
    chk("R5 erase strobe ignored", n, 0);
  endtask

  task automatic t_both_mode();
    int n;
    cfg(8'h03);
    strobe(1);
    count_low(n);
    chk("R6 erase pulse", n, PW);
    strobe(2);
    count_low(n);
    chk("R6 program pulse", n, PW);
    // retrigger: erase, 20 cycles later program
    strobe(1);
    n = 0;
    repeat (20) begin
      if (sts_pin == 1'b0) n++;
      @(negedge clk);
    end
    prog_done = 1'b1;
    if (sts_pin == 1'b0) n++;
    @(negedge clk);
    prog_done = 1'b0;
    while (sts_pin == 1'b0 && n < 400) begin
      n++;
      @(negedge clk);
    end
    chk("R8 retrigger extends", n, 20 + 1 + PW);
  endtask

  task automatic t_back_level();
    cfg(8'h00);
    chk("R9 no error", sr_set, 0);
    set_flags(1, 0);
    chk("R9 level busy low", sts_pin, 0);
    set_flags(0, 0);
    strobe(3);
    chk("R9 strobe no pulse", sts_pin, 1);
  endtask

  task automatic t_invalid();
    int n;
    cfg(8'h01);
    cfg(8'h05);
    chk("R10 error mask", sr_set, 8'h30);
    @(negedge clk);
    chk("R10 mask one cycle", sr_set, 0);
    cfg(8'h80);
    chk("R10 high code mask", sr_set, 8'h30);
    strobe(1);
    count_low(n);
    chk("R10 mode kept", n, PW);
  endtask

  task automatic t_busy_reject();
    cfg(8'h00);
    dev_busy = 1'b1;
    cfg(8'h03);
    chk("R11 busy mask", sr_set, 8'h30);
    chk("R11 still level busy", sts_pin, 0);
    dev_busy = 1'b0; dev_susp = 1'b1;
    cfg(8'h01);
    chk("R11 suspend mask", sr_set, 8'h30);
    set_flags(0, 0);
    strobe(1);
    chk("R11 no pulse mode", sts_pin, 1);
    set_flags(1, 0);
    chk("R11 level after reject", sts_pin, 0);
    set_flags(0, 0);
  endtask

  task automatic t_no_setup();
    wr(8'h03);
    chk("R13 bare code no error", sr_set, 0);
    wr(8'h01);
    chk("R13 second bare code no error", sr_set, 0);
    set_flags(1, 0);
    chk("R13 still level", sts_pin, 0);
    set_flags(0, 0);
  endtask

  task automatic t_reset_mid();
    cfg(8'h01);
    strobe(1);
    chk("R12 pulse started", sts_pin, 0);
    do_reset();
    chk("R12 pin high after reset", sts_pin, 1);
    strobe(1);
    chk("R12 no pulse after reset", sts_pin, 1);
    set_flags(1, 0);
    chk("R12 level busy", sts_pin, 0);
    set_flags(0, 0);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_level();
    t_erase_mode();
    t_prog_mode();
    t_both_mode();
    t_back_level();
    t_invalid();
    t_busy_reject();
    t_no_setup();
    t_reset_mid();
    void'(dummy(0));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule